// File: doc/BRIEF.md
# Subaddressed Register and Palette Access Port

This block sits behind a two-wire serial slave whose bit-level framing has already been reduced to byte strobes. A start (or repeated start) pulse and a stop pulse mark the transfer boundaries. Each received byte arrives with a one-cycle valid strobe. Each byte the master pulls in a read is announced by a one-cycle request strobe, and `tx_data` presents that byte combinationally in the same cycle.

After a start, the first byte selects the device: the upper seven bits hold the device address and bit 0 gives the direction (0 = write, 1 = read). In a write, the next byte is a subaddress and the bytes after it are data. Ordinary subaddresses reach a small file of control registers and advance by one after every byte. Two of those subaddresses are read-only status bytes fed from outside.

Two subaddresses open windows into table storage. Subaddress 0xFF opens a colour table of three 256-byte banks: one byte sets the table address, then bytes flow red, green, blue, and the table address advances after each blue byte. Subaddress 0xFE opens a 256-byte cursor bitmap with one byte per table address. Reads follow the same orderings.

Top module: `palreg_port`

## Requirements
- R1: The port answers only to a first byte whose bits [7:1] equal 7'h44 (0x88 write, 0x89 read): `rx_ack` is high in that byte's cycle, and any other first byte gets no acknowledge and no later byte of that transfer changes any state.
- R2: In a write, the first byte after the device byte is taken as the subaddress; a start or stop pulse returns the byte phase so that the byte after the next device byte is again a subaddress.
- R3: Writable control registers sit at subaddresses 2 to 15; each data byte written or read advances the subaddress by one, and written values show on `cfg_flat` (register n at bits [8n+7:8n]) one cycle after the byte strobe.
- R4: Subaddresses 0x00 and 0x01 read back `stat_a` and `stat_b`; writes to them are ignored (their `cfg_flat` slots stay zero), yet the subaddress still advances.
- R5: After subaddress 0xFF, the next written byte sets the table address and the following bytes fill red, green, blue in turn; after blue the table address rises by one, wrapping from 255 to 0.
- R6: Reads in the 0xFF window return red, green, blue of the current table address, then the next address; every start pulse returns the colour position to red while keeping the table address.
- R7: After subaddress 0xFE, the next written byte sets the table address, and every later data byte written or read touches one cursor byte and advances the table address by one.
- R8: Subaddresses 0x10 to 0xFD hold nothing: writes there change no state and reads there return 0x00.
- R9: After reset, all `cfg_flat` bits are zero, the subaddress is 0x00, no byte is acknowledged until a start, and table contents are zero.
- R10: `tx_data` always shows the byte at the current read position; a `tx_req` strobe during a read transfer consumes it and moves the position for the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_start | input | 1 | Start or repeated-start pulse |
| bus_stop | input | 1 | Stop pulse |
| rx_valid | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received byte |
| rx_ack | output | 1 | Acknowledge for the byte strobed this cycle |
| tx_req | input | 1 | Master consumes the presented read byte |
| tx_data | output | 8 | Byte at the current read position |
| stat_a | input | 8 | Read-only status byte at subaddress 0x00 |
| stat_b | input | 8 | Read-only status byte at subaddress 0x01 |
| cfg_flat | output | 128 | Control register contents, register n at bits [8n+7:8n] |

## Verification
`rx_ack` and `tx_data` are combinational, so the bench samples them in the very cycle its strobe is held. A register write shows on `cfg_flat` one edge after the byte strobe, and any pointer move from a byte or a read request shows on `tx_data` one edge later as well. The behavioural model in the bench updates on the same edge as the design. It is compared at the falling edge, so every comparison falls half a cycle after each result becomes due. Directed checks read table contents back through the read path and sample at the same point.

// File: rtl/palreg_pkg.sv
package palreg_pkg;

    localparam int          BYTE_W  = 8;
    localparam logic [7:0]  SUB_PAL = 8'hFF;
    localparam logic [7:0]  SUB_CUR = 8'hFE;
    localparam logic [1:0]  LAST_COL = 2'd2;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_DEVADDR,
        PH_SUB,
        PH_TADDR,
        PH_DATA
    } phase_e;

    typedef enum logic [1:0] {
        TG_REG,
        TG_PAL,
        TG_CUR
    } target_e;

    typedef struct packed {
        logic               wr;
        logic               adv;
        target_e            tgt;
        logic [BYTE_W-1:0]  sub;
        logic [BYTE_W-1:0]  tptr;
        logic [1:0]         col;
        logic [BYTE_W-1:0]  wdata;
    } access_t;

    function automatic target_e target_of(input logic [BYTE_W-1:0] s);
        if (s == SUB_PAL)      return TG_PAL;
        else if (s == SUB_CUR) return TG_CUR;
        else                   return TG_REG;
    endfunction

endpackage

// File: rtl/palreg_seq.sv
module palreg_seq
    import palreg_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h44
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_start,
    input  logic        bus_stop,
    input  logic        rx_valid,
    input  logic [7:0]  rx_byte,
    input  logic        tx_req,
    output logic        rx_ack,
    output access_t     acc
);

    phase_e      phase;
    logic        rd_mode;
    logic [7:0]  sub;
    logic [7:0]  tptr;
    logic [1:0]  col;
    logic        match;
    logic        quiet;
    logic        data_wr;
    logic        data_rd;
    logic        adv;
    target_e     tgt;

    assign match   = (rx_byte[7:1] == DEV_ADDR);
    assign quiet   = !bus_start && !bus_stop;
    assign tgt     = target_of(sub);
    assign data_wr = quiet && rx_valid && (phase == PH_DATA) && !rd_mode;
    assign data_rd = quiet && tx_req && (phase == PH_DATA) && rd_mode;
    assign adv     = data_wr || data_rd;

    always_comb begin
        rx_ack = 1'b0;
        if (rx_valid) begin
            unique case (phase)
                PH_DEVADDR:       rx_ack = match;
                PH_SUB, PH_TADDR: rx_ack = 1'b1;
                PH_DATA:          rx_ack = !rd_mode;
                default:          rx_ack = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_IDLE;
            rd_mode <= 1'b0;
            sub     <= '0;
            tptr    <= '0;
            col     <= '0;
        end else if (bus_start) begin
            phase <= PH_DEVADDR;
            col   <= '0;
        end else if (bus_stop) begin
            phase <= PH_IDLE;
        end else begin
            if (rx_valid) begin
                unique case (phase)
                    PH_DEVADDR: begin
                        if (match) begin
                            rd_mode <= rx_byte[0];
                            phase   <= rx_byte[0] ? PH_DATA : PH_SUB;
                        end else begin
                            phase <= PH_IDLE;
                        end
                    end
                    PH_SUB: begin
                        sub   <= rx_byte;
                        col   <= '0;
                        phase <= (target_of(rx_byte) == TG_REG) ? PH_DATA : PH_TADDR;
                    end
                    PH_TADDR: begin
                        tptr  <= rx_byte;
                        col   <= '0;
                        phase <= PH_DATA;
                    end
                    default: ;
                endcase
            end
            if (adv) begin
                unique case (tgt)
                    TG_PAL: begin
                        if (col == LAST_COL) begin
                            col  <= '0;
                            tptr <= tptr + 8'd1;
                        end else begin
                            col <= col + 2'd1;
                        end
                    end
                    TG_CUR:  tptr <= tptr + 8'd1;
                    default: sub  <= sub + 8'd1;
                endcase
            end
        end
    end

    assign acc = '{wr: data_wr, adv: adv, tgt: tgt, sub: sub, tptr: tptr,
                   col: col, wdata: rx_byte};

    p_start_phase_r2: assert property (@(posedge clk) disable iff (rst)
        bus_start |=> (phase == PH_DEVADDR && col == 2'd0));

    p_stop_idle_r2: assert property (@(posedge clk) disable iff (rst)
        (bus_stop && !bus_start) |=> (phase == PH_IDLE));

    p_miss_drop_r1: assert property (@(posedge clk) disable iff (rst)
        (quiet && rx_valid && phase == PH_DEVADDR && !match) |=> (phase == PH_IDLE));

    p_sub_step_r3: assert property (@(posedge clk) disable iff (rst)
        (adv && tgt == TG_REG) |=> (sub == $past(sub) + 8'd1));

    p_col_range_r5: assert property (@(posedge clk) disable iff (rst)
        col <= LAST_COL);

    p_pal_step_r5: assert property (@(posedge clk) disable iff (rst)
        (adv && tgt == TG_PAL && col == LAST_COL) |=> (col == 2'd0 && tptr == $past(tptr) + 8'd1));

    p_cur_step_r7: assert property (@(posedge clk) disable iff (rst)
        (adv && tgt == TG_CUR) |=> (tptr == $past(tptr) + 8'd1 && $stable(sub)));

endmodule

// File: rtl/palreg_regs.sv
module palreg_regs #(
    parameter int REG_COUNT  = 16,
    parameter int STAT_A_SUB = 0,
    parameter int STAT_B_SUB = 1,
    localparam int FLAT_W    = REG_COUNT * 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [7:0]        sub,
    input  logic [7:0]        wdata,
    input  logic [7:0]        stat_a,
    input  logic [7:0]        stat_b,
    output logic [7:0]        rdata,
    output logic [FLAT_W-1:0] cfg_flat
);

    for (genvar g = 0; g < REG_COUNT; g++) begin : g_slot
        localparam logic [7:0] SLOT = 8'(g);
        if (g == STAT_A_SUB || g == STAT_B_SUB) begin : g_ro
            assign cfg_flat[g*8 +: 8] = '0;
        end else begin : g_rw
            logic [7:0] q;
            always_ff @(posedge clk) begin
                if (rst)                      q <= '0;
                else if (wr && sub == SLOT)   q <= wdata;
            end
            assign cfg_flat[g*8 +: 8] = q;
        end
    end

    always_comb begin
        rdata = '0;
        if (sub == 8'(STAT_A_SUB))      rdata = stat_a;
        else if (sub == 8'(STAT_B_SUB)) rdata = stat_b;
        else begin
            for (int i = 0; i < REG_COUNT; i++) begin
                if (sub == 8'(i)) rdata = cfg_flat[i*8 +: 8];
            end
        end
    end

    p_status_ro_r4: assert property (@(posedge clk) disable iff (rst)
        (wr && (sub == 8'(STAT_A_SUB) || sub == 8'(STAT_B_SUB))) |=> $stable(cfg_flat));

    p_empty_sub_r8: assert property (@(posedge clk) disable iff (rst)
        (wr && sub >= 8'(REG_COUNT)) |=> $stable(cfg_flat));

endmodule

// File: rtl/palreg_ram.sv
module palreg_ram #(
    parameter int DEPTH = 256,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata
);

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[addr] <= wdata;
        end
    end

    assign rdata = mem[addr];

endmodule

// File: rtl/palreg_port.sv
module palreg_port
    import palreg_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR  = 7'h44,
    parameter int         REG_COUNT = 16,
    localparam int        BANKS     = 4,
    localparam int        FLAT_W    = REG_COUNT * 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_start,
    input  logic              bus_stop,
    input  logic              rx_valid,
    input  logic [7:0]        rx_byte,
    output logic              rx_ack,
    input  logic              tx_req,
    output logic [7:0]        tx_data,
    input  logic [7:0]        stat_a,
    input  logic [7:0]        stat_b,
    output logic [FLAT_W-1:0] cfg_flat
);

    access_t    acc;
    logic [7:0] reg_rd;
    logic [7:0] bank_rd [BANKS];

    palreg_seq #(.DEV_ADDR(DEV_ADDR)) i_seq (
        .clk(clk), .rst(rst), .bus_start(bus_start), .bus_stop(bus_stop),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .tx_req(tx_req),
        .rx_ack(rx_ack), .acc(acc)
    );

    palreg_regs #(.REG_COUNT(REG_COUNT)) i_regs (
        .clk(clk), .rst(rst),
        .wr(acc.wr && acc.tgt == TG_REG), .sub(acc.sub), .wdata(acc.wdata),
        .stat_a(stat_a), .stat_b(stat_b), .rdata(reg_rd), .cfg_flat(cfg_flat)
    );

    // banks 0..2 hold red, green, blue; bank 3 holds the cursor bitmap
    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        logic we_b;
        if (b < 3) begin : g_col
            assign we_b = acc.wr && acc.tgt == TG_PAL && acc.col == 2'(b);
        end else begin : g_cur
            assign we_b = acc.wr && acc.tgt == TG_CUR;
        end
        palreg_ram #(.DEPTH(256)) i_ram (
            .clk(clk), .rst(rst), .we(we_b), .addr(acc.tptr),
            .wdata(acc.wdata), .rdata(bank_rd[b])
        );
    end

    always_comb begin
        unique case (acc.tgt)
            TG_PAL:  tx_data = bank_rd[acc.col];
            TG_CUR:  tx_data = bank_rd[3];
            default: tx_data = reg_rd;
        endcase
    end

endmodule

// File: tb/test_palreg_port.sv
module test_palreg_port;

    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         bus_start = 1'b0, bus_stop = 1'b0, rx_valid = 1'b0, tx_req = 1'b0;
    logic [7:0]   rx_byte = 8'h00;
    logic         rx_ack;
    logic [7:0]   tx_data;
    logic [7:0]   stat_a = 8'hC3, stat_b = 8'h3C;
    logic [127:0] cfg_flat;

    int errors = 0, checks = 0;
    bit done = 1'b0;
    logic       last_ack;
    logic [7:0] last_rd;

    always #(CLK_PERIOD/2) clk = ~clk;

    palreg_port i_palreg_port (
        .clk(clk), .rst(rst), .bus_start(bus_start), .bus_stop(bus_stop),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_ack(rx_ack),
        .tx_req(tx_req), .tx_data(tx_data), .stat_a(stat_a), .stat_b(stat_b),
        .cfg_flat(cfg_flat)
    );

    // behavioural reference: phase 0 idle, 1 device byte, 2 subaddress, 3 table address, 4 data
    int m_ph, m_sub, m_tp, m_col;
    bit m_rd;
    int m_regs [16];
    int m_pal [3][256];
    int m_cur [256];

    function automatic int m_read();
        if (m_sub == 255) return m_pal[m_col][m_tp];
        if (m_sub == 254) return m_cur[m_tp];
        if (m_sub == 0)   return int'(stat_a);
        if (m_sub == 1)   return int'(stat_b);
        if (m_sub < 16)   return m_regs[m_sub];
        return 0;
    endfunction

    function automatic void m_step();
        if (m_sub == 255) begin
            if (m_col == 2) begin m_col = 0; m_tp = (m_tp + 1) % 256; end
            else m_col++;
        end else if (m_sub == 254) m_tp = (m_tp + 1) % 256;
        else m_sub = (m_sub + 1) % 256;
    endfunction

    always @(posedge clk) begin
        int ph;
        ph = m_ph;
        if (rst) begin
            m_ph = 0; m_rd = 0; m_sub = 0; m_tp = 0; m_col = 0;
            foreach (m_regs[i]) m_regs[i] = 0;
            foreach (m_cur[i]) m_cur[i] = 0;
            for (int c = 0; c < 3; c++) for (int i = 0; i < 256; i++) m_pal[c][i] = 0;
        end else if (bus_start) begin
            m_ph = 1; m_col = 0;
        end else if (bus_stop) begin
            m_ph = 0;
        end else begin
            if (rx_valid) begin
                if (ph == 1) begin
                    if (rx_byte[7:1] == 7'h44) begin m_rd = rx_byte[0]; m_ph = m_rd ? 4 : 2; end
                    else m_ph = 0;
                end else if (ph == 2) begin
                    m_sub = rx_byte; m_col = 0; m_ph = (rx_byte >= 8'hFE) ? 3 : 4;
                end else if (ph == 3) begin
                    m_tp = rx_byte; m_col = 0; m_ph = 4;
                end else if (ph == 4 && !m_rd) begin
                    if (m_sub == 255) m_pal[m_col][m_tp] = rx_byte;
                    else if (m_sub == 254) m_cur[m_tp] = rx_byte;
                    else if (m_sub > 1 && m_sub < 16) m_regs[m_sub] = rx_byte;
                    m_step();
                end
            end
            if (tx_req && ph == 4 && m_rd) m_step();
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model, half a cycle after each edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            logic exp_ack;
            logic [127:0] exp_cfg;
            exp_ack = rx_valid && ((m_ph == 1 && rx_byte[7:1] == 7'h44) ||
                                   m_ph == 2 || m_ph == 3 || (m_ph == 4 && !m_rd));
            for (int i = 0; i < 16; i++) exp_cfg[i*8 +: 8] = 8'(m_regs[i]);
            chk("R1 ack", int'(rx_ack), int'(exp_ack));
            chk("R10 tx_data", int'(tx_data), m_read());
            checks++;
            if (cfg_flat !== exp_cfg) begin
                errors++;
                $display("FAIL R3 cfg actual=%h expected=%h", cfg_flat, exp_cfg);
            end
        end
    end

    task automatic tick_set();
        @(posedge clk); #1;
    endtask

    task automatic do_start();
        tick_set(); bus_start = 1'b1;
        tick_set(); bus_start = 1'b0;
    endtask

    task automatic do_stop();
        tick_set(); bus_stop = 1'b1;
        tick_set(); bus_stop = 1'b0;
    endtask

    task automatic send(input logic [7:0] b);
        tick_set(); rx_valid = 1'b1; rx_byte = b;
        @(negedge clk); last_ack = rx_ack;
        tick_set(); rx_valid = 1'b0;
    endtask

    task automatic pull();
        tick_set(); tx_req = 1'b1;
        @(negedge clk); last_rd = tx_data;
        tick_set(); tx_req = 1'b0;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++; checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk("R9 cfg reset", int'(cfg_flat == '0), 1);
        chk("R9 tx at sub 0", int'(tx_data), 'hC3);
        chk("R9 no ack before start", int'(rx_ack), 0);

        // R1: foreign address, nothing lands
        do_start(); send(8'h90);
        chk("R1 foreign nack", int'(last_ack), 0);
        send(8'h05); send(8'hAA); do_stop();
        chk("R1 foreign no write", int'(cfg_flat[5*8 +: 8]), 0);

        // R3: burst write with auto-increment
        do_start(); send(8'h88);
        chk("R1 own ack", int'(last_ack), 1);
        send(8'h04); send(8'h11); send(8'h22); send(8'h33); do_stop();
        chk("R3 reg4", int'(cfg_flat[4*8 +: 8]), 'h11);
        chk("R3 reg6", int'(cfg_flat[6*8 +: 8]), 'h33);
        do_start(); send(8'h88); send(8'h05); do_start(); send(8'h89);
        pull(); chk("R3 read reg5", int'(last_rd), 'h22);
        pull(); chk("R3 read reg6", int'(last_rd), 'h33);
        do_stop();

        // R4: status bytes
        do_start(); send(8'h88); send(8'h00); send(8'h77); send(8'h66); send(8'h55); do_stop();
        chk("R4 slot0 unchanged", int'(cfg_flat[7:0]), 0);
        chk("R4 slot1 unchanged", int'(cfg_flat[15:8]), 0);
        chk("R4 increment reaches reg2", int'(cfg_flat[23:16]), 'h55);
        do_start(); send(8'h88); send(8'h00); do_start(); send(8'h89);
        pull(); chk("R4 read stat_a", int'(last_rd), 'hC3);
        pull(); chk("R4 read stat_b", int'(last_rd), 'h3C);
        do_stop();

        // R2: phase reset by stop and by repeated start
        do_start(); send(8'h88); send(8'h08); do_stop();
        do_start(); send(8'h88); send(8'h09); send(8'h44); do_stop();
        chk("R2 after stop", int'(cfg_flat[9*8 +: 8]), 'h44);
        chk("R2 reg8 untouched", int'(cfg_flat[8*8 +: 8]), 0);
        do_start(); send(8'h88); send(8'h0A); send(8'h12);
        do_start(); send(8'h88); send(8'h0B); send(8'h34); do_stop();
        chk("R2 before restart", int'(cfg_flat[10*8 +: 8]), 'h12);
        chk("R2 after restart", int'(cfg_flat[11*8 +: 8]), 'h34);

        // R5 and R6: colour table with wrap
        do_start(); send(8'h88); send(8'hFF); send(8'hFE);
        for (int k = 1; k <= 9; k++) send(8'(k));
        do_stop();
        do_start(); send(8'h88); send(8'hFF); send(8'hFE); do_start(); send(8'h89);
        for (int k = 1; k <= 9; k++) begin
            pull(); chk("R5 R6 table order", int'(last_rd), k);
        end
        do_stop();
        do_start(); send(8'h88); send(8'hFF); send(8'hFF); do_start(); send(8'h89);
        pull(); chk("R6 red of 255", int'(last_rd), 4);
        pull(); chk("R6 green of 255", int'(last_rd), 5);
        do_start(); send(8'h89);
        pull(); chk("R6 start back to red", int'(last_rd), 4);
        do_stop();

        // R7: cursor bitmap
        do_start(); send(8'h88); send(8'hFE); send(8'h10); send(8'hA0); send(8'hA1); do_stop();
        do_start(); send(8'h88); send(8'hFE); send(8'h10); do_start(); send(8'h89);
        pull(); chk("R7 cursor 0x10", int'(last_rd), 'hA0);
        pull(); chk("R7 cursor 0x11", int'(last_rd), 'hA1);
        do_stop();

        // R8: empty subaddress
        do_start(); send(8'h88); send(8'h20); send(8'h5A); do_stop();
        do_start(); send(8'h88); send(8'h20); do_start(); send(8'h89);
        pull(); chk("R8 empty reads zero", int'(last_rd), 0);
        do_stop();
        chk("R8 regs unchanged", int'(cfg_flat[2*8 +: 8]), 'h55);

        repeat (2) @(posedge clk);
        finish_run();
    end

endmodule